// File: doc/BRIEF.md
# Priority Interrupt Controller with Claim-on-Read

This block gathers up to 32 interrupt lines and drives one interrupt request to a processor. Each line has a 4-bit priority and a disable flag in its own configuration word. A rising edge on a line marks that source as waiting. A waiting source takes part in arbitration only when it is enabled and its priority is below a 4-bit threshold. The processor sees a single registered request line. It learns which source won by reading an index register, and that read also claims the interrupt.

A claim saves the running threshold into a read-only saved-threshold register. It then drops the threshold to zero, so nothing else can interrupt the handler. At the end of the handler, software writes the saved value back to the threshold register. That write restores the threshold and also acknowledges the source that was claimed. Two 16-bit shorthand registers give a second view of the per-source disable flags, so software can switch whole groups of sources on or off with one write.

The register bus is word-addressed. Writes take effect at the clock edge. Read data is combinational, and the side effects of a claim happen at the clock edge of the read cycle.

Top module: `pic_claim`

## Requirements
- R1: After reset the threshold is 0xF, the saved threshold is 0, the last index reads 0x80, the global enable reads 1, the freeze register reads 0, every source is disabled with priority 0 (both shorthand registers read 0xFFFF), and the request output is low.
- R2: The configuration word of source N is at word address 2+N, with the priority in bits 3:0 and the disable flag in bit 6 (1 = disabled). Word 0 holds the disable flags of sources 0..15 and word 1 those of sources 16..31, with bit k standing for the k-th source of its group. A write to either view changes what the other view reads.
- R3: A source is eligible only when it is waiting, enabled, and its priority is strictly less than the threshold (word 36). A threshold of 0 blocks every source, and 0xF blocks only priority 15.
- R4: Reading the index register (word 34) returns the eligible source with the numerically lowest priority, with ties going to the lowest source number. It returns 0x80 when no source is eligible.
- R5: A read of word 34 that returns a source copies that number into the last-index register (word 35), copies the threshold into the saved-threshold register (word 37), and sets the threshold to 0. After this, word 34 reads 0x80.
- R6: Reading the last-index, saved-threshold and alias registers has no side effect. Words 40 and 41 are read-only aliases of the threshold and the saved threshold.
- R7: A write to word 36 loads the threshold and clears the waiting state of the source held in the last-index register. The last-index register keeps its value.
- R8: The global enable (word 38, bit 0) at 0 makes every source ineligible. Waiting sources are kept and return once it is set back to 1.
- R9: The freeze register (word 39, bit 0) at 1 blocks delivery and ignores line edges. An edge that arrives while frozen is lost.
- R10: A source becomes waiting on a rising edge of its line. A line held high after its acknowledge does not make the source wait again.
- R11: The request output goes high one clock after any source becomes eligible, and goes low one clock after none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | NUM_SRC | Interrupt lines from the sources |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; drives the claim side effects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The in-line assertions watch, on every cycle, that a claim closes the threshold and records the winner, that the reported winner is eligible and below the threshold, that an acknowledge clears the claimed source, that the request output never rises without something waiting, that a disabled global enable drops the request, and that nothing becomes waiting while frozen. Only the bench scenarios can show arbitration order across mixed patterns and tie-breaking, the two views of the disable flags agreeing, a held line not re-triggering, and an edge lost during a freeze staying lost.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int PRIO_W  = 4;
   localparam int GRP_W   = 16;
   localparam int DIS_BIT = 6;
   localparam logic [7:0] NO_IRQ = 8'h80;
   typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/pic_capture.sv
module pic_capture #(
   parameter int NUM_SRC = 32,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] lines_i,
   input  logic               freeze_i,
   input  logic               ack_valid_i,
   input  logic [IDX_W-1:0]   ack_idx_i,
   output logic [NUM_SRC-1:0] pend_o
);
   logic [NUM_SRC-1:0] line_q;
   logic [NUM_SRC-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '0;
      else        line_q <= lines_i;
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic rise, clr;
      assign rise = lines_i[s] && !line_q[s] && !freeze_i;
      assign clr  = ack_valid_i && (ack_idx_i == IDX_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    pend_q[s] <= 1'b0;
         else if (rise) pend_q[s] <= 1'b1;
         else if (clr)  pend_q[s] <= 1'b0;
      end
   end

   assign pend_o = pend_q;

   assert_frozen_no_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(freeze_i) |-> ((pend_q & ~$past(pend_q)) == '0));

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid_i && !lines_i[ack_idx_i]) |=> !pend_q[$past(ack_idx_i)]);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
   import pic_pkg::*;
#(
   parameter int NUM_SRC = 32,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0]             elig_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                           win_valid_o,
   output logic [IDX_W-1:0]               win_idx_o
);
   prio_t best;

   always_comb begin
      best        = '1;
      win_valid_o = 1'b0;
      win_idx_o   = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig_i[i] && (!win_valid_o || prio_i[i] <= best)) begin
            win_valid_o = 1'b1;
            best        = prio_i[i];
            win_idx_o   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/pic_claim.sv
module pic_claim
   import pic_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 6,
   parameter logic [PRIO_W-1:0] THR_INIT = 4'hF,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_lines,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               cpu_irq
);
   localparam int A_GRP0  = 0;
   localparam int A_GRP1  = 1;
   localparam int A_CFG0  = 2;
   localparam int A_IDX   = A_CFG0 + 32;
   localparam int A_LAST  = A_IDX + 1;
   localparam int A_THR   = A_IDX + 2;
   localparam int A_SAVE  = A_IDX + 3;
   localparam int A_GEN   = A_IDX + 4;
   localparam int A_FRZ   = A_IDX + 5;
   localparam int A_THR_M = A_IDX + 6;
   localparam int A_SAV_M = A_IDX + 7;

   if (NUM_SRC < 1 || NUM_SRC > 2 * GRP_W) begin : g_bad_src
      $error("pic_claim: NUM_SRC out of range");
   end
   if (A_SAV_M >= (1 << ADDR_W)) begin : g_bad_addr
      $error("pic_claim: ADDR_W too narrow for the register map");
   end

   prio_t [NUM_SRC-1:0] prio_q;
   logic  [NUM_SRC-1:0] dis_q;
   prio_t               thr_q, save_q;
   logic  [7:0]         last_q;
   logic                gen_q, frz_q, irq_q;

   logic [NUM_SRC-1:0] pend, elig;
   logic               win_valid;
   logic [IDX_W-1:0]   win_idx;
   logic               cfg_hit;
   logic [ADDR_W-1:0]  cfg_off;
   logic               claim_fire, ack_fire;
   logic               unused_wdata;

   assign unused_wdata = ^bus_wdata[31:GRP_W];

   assign cfg_off = bus_addr - ADDR_W'(A_CFG0);
   assign cfg_hit = (bus_addr >= ADDR_W'(A_CFG0)) && (cfg_off < ADDR_W'(NUM_SRC));

   // eligibility per source
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_elig
      assign elig[s] = pend[s] && !dis_q[s] && (prio_q[s] < thr_q) && gen_q && !frz_q;
   end

   pic_capture #(.NUM_SRC(NUM_SRC)) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .lines_i     (irq_lines),
      .freeze_i    (frz_q),
      .ack_valid_i (ack_fire),
      .ack_idx_i   (last_q[IDX_W-1:0]),
      .pend_o      (pend)
   );

   pic_arbiter #(.NUM_SRC(NUM_SRC)) u_arbiter (
      .elig_i      (elig),
      .prio_i      (prio_q),
      .win_valid_o (win_valid),
      .win_idx_o   (win_idx)
   );

   assign claim_fire = bus_rd && (bus_addr == ADDR_W'(A_IDX)) && win_valid;
   assign ack_fire   = bus_wr && (bus_addr == ADDR_W'(A_THR)) && !last_q[7];

   // per-source configuration and shorthand aliases
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_cfg
      localparam int GRP_ADDR = (s < GRP_W) ? A_GRP0 : A_GRP1;
      localparam int GRP_BIT  = s % GRP_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q[s] <= '0;
            dis_q[s]  <= 1'b1;
         end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_CFG0 + s)) begin
               prio_q[s] <= bus_wdata[PRIO_W-1:0];
               dis_q[s]  <= bus_wdata[DIS_BIT];
            end else if (bus_addr == ADDR_W'(GRP_ADDR)) begin
               dis_q[s]  <= bus_wdata[GRP_BIT];
            end
         end
      end
   end

   // threshold, claim and global controls
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= THR_INIT;
         save_q <= '0;
         last_q <= NO_IRQ;
         gen_q  <= 1'b1;
         frz_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= |elig;
         if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_THR)) thr_q <= bus_wdata[PRIO_W-1:0];
            if (bus_addr == ADDR_W'(A_GEN)) gen_q <= bus_wdata[0];
            if (bus_addr == ADDR_W'(A_FRZ)) frz_q <= bus_wdata[0];
         end
         if (claim_fire) begin
            last_q <= 8'(win_idx);
            save_q <= thr_q;
            thr_q  <= '0;
         end
      end
   end

   assign cpu_irq = irq_q;

   // read mux
   logic [GRP_W-1:0] grp_lo, grp_hi;
   always_comb begin
      grp_lo = '1;
      grp_hi = '1;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (s < GRP_W) grp_lo[s]         = dis_q[s];
         else           grp_hi[s - GRP_W] = dis_q[s];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (cfg_hit) begin
         bus_rdata[PRIO_W-1:0] = prio_q[cfg_off[IDX_W-1:0]];
         bus_rdata[DIS_BIT]    = dis_q[cfg_off[IDX_W-1:0]];
      end else begin
         case (bus_addr)
            ADDR_W'(A_GRP0):  bus_rdata[GRP_W-1:0]  = grp_lo;
            ADDR_W'(A_GRP1):  bus_rdata[GRP_W-1:0]  = grp_hi;
            ADDR_W'(A_IDX):   bus_rdata[7:0]        = win_valid ? 8'(win_idx) : NO_IRQ;
            ADDR_W'(A_LAST):  bus_rdata[7:0]        = last_q;
            ADDR_W'(A_THR),
            ADDR_W'(A_THR_M): bus_rdata[PRIO_W-1:0] = thr_q;
            ADDR_W'(A_SAVE),
            ADDR_W'(A_SAV_M): bus_rdata[PRIO_W-1:0] = save_q;
            ADDR_W'(A_GEN):   bus_rdata[0]          = gen_q;
            ADDR_W'(A_FRZ):   bus_rdata[0]          = frz_q;
            default:          bus_rdata             = '0;
         endcase
      end
   end

   assert_claim_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      claim_fire |=> (thr_q == '0) && (last_q == 8'($past(win_idx))) && (save_q == $past(thr_q)));

   assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> pend[win_idx] && !dis_q[win_idx]);

   assert_winner_below_thr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (prio_q[win_idx] < thr_q));

   assert_irq_needs_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_irq) |-> $past(|pend));

   assert_gen_off_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_q |=> !cpu_irq);
endmodule

// File: tb/pic_claim_tb.sv
module pic_claim_tb;
   localparam int A_GRP0 = 0, A_GRP1 = 1, A_CFG0 = 2, A_IDX = 34, A_LAST = 35;
   localparam int A_THR = 36, A_SAVE = 37, A_GEN = 38, A_FRZ = 39, A_THR_M = 40, A_SAV_M = 41;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_lines = '0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cpu_irq;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pic_claim u_dut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
   );

   // {pulse mask, expected index}; priority of source i is i>>1, threshold 0xF
   localparam logic [39:0] VEC [8] = '{
      {32'h0000_0008, 8'h03},
      {32'h0000_0030, 8'h04},
      {32'h8000_0000, 8'h80},
      {32'h0010_0100, 8'h08},
      {32'h0000_0003, 8'h00},
      {32'h4000_2000, 8'h0D},
      {32'h00C0_0000, 8'h16},
      {32'h0000_0000, 8'h80}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_addr = 6'(a); bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 6'(a); bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1 bus_rd = 1'b0;
   endtask

   task automatic pulse(logic [31:0] m);
      @(negedge clk); irq_lines = irq_lines | m;
      @(negedge clk); irq_lines = irq_lines & ~m;
      @(negedge clk); #1;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; irq_lines = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic setup();
      for (int i = 0; i < 32; i++) wr(A_CFG0 + i, 32'(i >> 1));
   endtask

   task automatic drain();
      logic [31:0] d;
      for (int k = 0; k < 40; k++) begin
         rd(A_IDX, d);
         if (d == 32'h80) break;
         wr(A_THR, 32'hF);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      do_reset();
      @(negedge clk); #1;
      // R1 reset state
      check("R1 irq", 32'(cpu_irq), 0);
      rd(A_THR_M, d); check("R1 thr", d, 32'hF);
      rd(A_SAVE, d);  check("R1 save", d, 0);
      rd(A_LAST, d);  check("R1 last", d, 32'h80);
      rd(A_GEN, d);   check("R1 gen", d, 1);
      rd(A_FRZ, d);   check("R1 frz", d, 0);
      rd(A_GRP0, d);  check("R1 grp0", d, 32'hFFFF);
      rd(A_GRP1, d);  check("R1 grp1", d, 32'hFFFF);
      rd(A_CFG0 + 5, d); check("R1 cfg", d, 32'h40);

      setup();
      // R4 R11 vector table
      for (int v = 0; v < 8; v++) begin
         pulse(VEC[v][39:8]);
         check("R11 irq", 32'(cpu_irq), (VEC[v][7:0] != 8'h80) ? 1 : 0);
         rd(A_IDX, d);
         check("R4 idx", d, 32'(VEC[v][7:0]));
         if (d != 32'h80) wr(A_THR, 32'hF);
         drain();
      end

      do_reset();
      setup();
      // R2 aliasing
      rd(A_GRP0, d); check("R2 grp0", d, 0);
      wr(A_CFG0 + 17, 32'h48);
      rd(A_GRP1, d); check("R2 grp1", d, 32'h0002);
      wr(A_GRP1, 32'h0000);
      rd(A_CFG0 + 17, d); check("R2 cfg17", d, 32'h08);

      // R5 R6 R7 R10 claim, ack, held line
      @(negedge clk); irq_lines[9] = 1'b1;
      repeat (2) @(negedge clk); #1;
      check("R11 irq up", 32'(cpu_irq), 1);
      rd(A_IDX, d);   check("R4 claim idx", d, 9);
      rd(A_IDX, d);   check("R5 idx after", d, 32'h80);
      rd(A_LAST, d);  check("R5 last", d, 9);
      rd(A_LAST, d);  check("R6 last again", d, 9);
      rd(A_SAVE, d);  check("R5 save", d, 32'hF);
      rd(A_SAV_M, d); check("R6 save alias", d, 32'hF);
      rd(A_THR_M, d); check("R5 thr closed", d, 0);
      @(negedge clk); #1 check("R11 irq down", 32'(cpu_irq), 0);
      wr(A_THR, 32'hF);
      rd(A_IDX, d);   check("R10 held line", d, 32'h80);
      rd(A_THR, d);   check("R7 thr", d, 32'hF);
      rd(A_LAST, d);  check("R7 last kept", d, 9);
      @(negedge clk); irq_lines[9] = 1'b0;

      // R3 threshold compare
      wr(A_THR, 32'h4);
      pulse(32'h0000_0100);
      rd(A_IDX, d);   check("R3 prio eq thr", d, 32'h80);
      pulse(32'h0000_0080);
      rd(A_IDX, d);   check("R3 prio below", d, 7);
      wr(A_THR, 32'h4);
      wr(A_THR, 32'h5);
      rd(A_IDX, d);   check("R3 thr raised", d, 8);
      wr(A_THR, 32'hF);
      rd(A_IDX, d);   check("R7 acked", d, 32'h80);

      // R8 global enable
      pulse(32'h0000_0004);
      wr(A_GEN, 0);
      rd(A_IDX, d);   check("R8 gen off idx", d, 32'h80);
      @(negedge clk); #1 check("R8 gen off irq", 32'(cpu_irq), 0);
      wr(A_GEN, 1);
      rd(A_IDX, d);   check("R8 gen on", d, 2);
      wr(A_THR, 32'hF);

      // R9 freeze
      pulse(32'h0000_0008);
      wr(A_FRZ, 1);
      rd(A_IDX, d);   check("R9 frozen idx", d, 32'h80);
      pulse(32'h0000_1000);
      wr(A_FRZ, 0);
      rd(A_IDX, d);   check("R9 kept", d, 3);
      wr(A_THR, 32'hF);
      rd(A_IDX, d);   check("R9 lost edge", d, 32'h80);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule